// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a single-data-rate DRAM out of power-up before any read or write traffic is allowed. After system reset it keeps the clock enable low and the DRAM in no-operation, and waits for an indication that supply and clock are stable. It then raises the clock enable and issues a fixed series of commands: a precharge of all banks, two auto-refresh commands and a mode-register load. Each command is followed by the timing gap the DRAM requires. It finishes in a ready state and raises a done flag that stays high until the next reset.

Every timing gap is given as a time in picoseconds together with the clock period, and the number of wait cycles is derived from them when the design is elaborated. When the clock period already covers a gap, the wait state for that gap is removed and the next command follows on the very next cycle. One shared cycle counter times all waits. It is cleared on every state change and counts up while a wait state is held. The mode word placed on the address lines during the load is built from a burst-length code, a burst-order bit and a CAS-latency code. Once the block is ready, the mode register can be loaded again with new field values by pulsing a reload request.

All pins are plain control and status signals. There is no data stream, so there is no valid/ready handshake. The current sequencer state is exported so that downstream command logic can hold off until initialization is complete.

Top module: `sdr_init_seq`

## Requirements
- R1: From reset, and for as long as `pwr_stable` stays low, `seq_state` is 0, the command {cs_n,ras_n,cas_n,we_n} is NOP (0111), `mem_cke` is 0 and `init_done` is 0.
- R2: On the first clock edge in state 0 with `pwr_stable` high, the block enters state 1 for exactly one cycle with `mem_cke` at 1 and a NOP command. A precharge follows on the next cycle, and `mem_cke` stays 1 until the next reset.
- R3: The commands are issued in this order: PRECHARGE 0010 with address bit 10 high (state 2), AUTO REFRESH 0001 (state 4), AUTO REFRESH 0001 (state 6), LOAD MODE 0000 (state 8), then the ready state 10. Each command lasts one cycle.
- R4: After a command whose gap is t, the block holds a NOP wait state for ceil(t/tCK)-1 cycles before the next step. The wait states are 3 after the precharge (tRP), 5 and 7 after each refresh (tRFC), and 9 after the load (tMRD).
- R5: When ceil(t/tCK)-1 is 0, that wait state never occurs and the next command follows on the very next cycle.
- R6: During LOAD MODE the address carries `burst_len` on bits 2:0, `burst_ilv` on bit 3 and `cas_lat` on bits 6:4, with every other address bit 0 and the bank bits 0.
- R7: `init_done` rises in the same cycle that `seq_state` first becomes 10 and stays high until reset, including during a mode reload.
- R8: In state 10, `mode_reload` high at a clock edge moves the block to LOAD MODE (state 8) with the current field values. The tMRD wait follows, and the block then returns to state 10.
- R9: `mode_reload` has no effect in any state other than 10.
- R10: An active-low reset at any point returns all outputs at once to the values in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_stable | input | 1 | Supply and clock are stable; starts the sequence |
| mode_reload | input | 1 | Request a new mode-register load while ready |
| burst_len | input | 3 | Burst-length code for the mode word |
| burst_ilv | input | 1 | Burst order: 0 sequential, 1 interleaved |
| cas_lat | input | 3 | CAS-latency code for the mode word |
| mem_cke | output | 1 | DRAM clock enable |
| mem_cs_n | output | 1 | DRAM chip select, active low |
| mem_ras_n | output | 1 | DRAM row strobe, active low |
| mem_cas_n | output | 1 | DRAM column strobe, active low |
| mem_we_n | output | 1 | DRAM write enable, active low |
| mem_addr | output | ADDR_W | DRAM address lines |
| mem_ba | output | BA_W | DRAM bank select |
| seq_state | output | 4 | Current sequencer state code |
| init_done | output | 1 | Sticky initialization-complete flag |

## Verification
The sequence is checked cycle by cycle against a table of expected phases under two timing sets. The first has gaps several clock periods long, which exercises the wait states and the shared counter's exit count. The second has a clock period that covers every gap, which separates a correct bypass from a design that always inserts a wait. The reload request is held high during the whole start-up walk, which shows whether it leaks into the start-up path. It is then pulsed in the ready state with new field values, which shows that the mode word follows the live inputs and that the done flag stays high. A reset is also applied in the middle of a refresh wait, to confirm that it returns the block to the idle values.

// File: rtl/sdr_init_pkg.sv
`timescale 1ns/1ps
package sdr_init_pkg;

  typedef enum logic [3:0] {
    S_IDLE    = 4'd0,
    S_CKE_UP  = 4'd1,
    S_PRE     = 4'd2,
    S_W_PRE   = 4'd3,
    S_REF_A   = 4'd4,
    S_W_REF_A = 4'd5,
    S_REF_B   = 4'd6,
    S_W_REF_B = 4'd7,
    S_LOAD    = 4'd8,
    S_W_LOAD  = 4'd9,
    S_READY   = 4'd10
  } init_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } mem_cmd_t;

  localparam mem_cmd_t CMD_NOP  = 4'b0111;
  localparam mem_cmd_t CMD_PRE  = 4'b0010;
  localparam mem_cmd_t CMD_AREF = 4'b0001;
  localparam mem_cmd_t CMD_LOAD = 4'b0000;

  // Number of NOP cycles that must separate a command from the next one:
  // ceil(t/tCK) cycles in total, one of which is the command cycle itself.
  function automatic int gap_cycles(input int t_ps, input int clk_ps);
    int total;
    if (t_ps <= clk_ps) return 0;
    total = (t_ps + clk_ps - 1) / clk_ps;
    return total - 1;
  endfunction

endpackage

// File: rtl/sdr_init_timer.sv
`timescale 1ns/1ps
module sdr_init_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  // Shared wait counter: cleared on every state change, saturates when held.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (cnt != TOP) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sdr_init_fsm.sv
`timescale 1ns/1ps
module sdr_init_fsm
  import sdr_init_pkg::*;
#(
  parameter int WAIT_RP  = 2,
  parameter int WAIT_RFC = 11,
  parameter int WAIT_MRD = 1,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_stable,
  input  logic             mode_reload,
  input  logic [CNT_W-1:0] cnt,
  output init_state_e      state,
  output logic             cnt_clr,
  output logic             done
);
  // A gap of zero cycles removes its wait state from the graph entirely.
  localparam init_state_e AFTER_PRE   = (WAIT_RP  > 0) ? S_W_PRE   : S_REF_A;
  localparam init_state_e AFTER_REF_A = (WAIT_RFC > 0) ? S_W_REF_A : S_REF_B;
  localparam init_state_e AFTER_REF_B = (WAIT_RFC > 0) ? S_W_REF_B : S_LOAD;
  localparam init_state_e AFTER_LOAD  = (WAIT_MRD > 0) ? S_W_LOAD  : S_READY;

  localparam logic [CNT_W-1:0] RP_LAST  = CNT_W'(WAIT_RP  - 1);
  localparam logic [CNT_W-1:0] RFC_LAST = CNT_W'(WAIT_RFC - 1);
  localparam logic [CNT_W-1:0] MRD_LAST = CNT_W'(WAIT_MRD - 1);

  init_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:    if (pwr_stable) nxt = S_CKE_UP;
      S_CKE_UP:  nxt = S_PRE;
      S_PRE:     nxt = AFTER_PRE;
      S_W_PRE:   if (cnt == RP_LAST)  nxt = S_REF_A;
      S_REF_A:   nxt = AFTER_REF_A;
      S_W_REF_A: if (cnt == RFC_LAST) nxt = S_REF_B;
      S_REF_B:   nxt = AFTER_REF_B;
      S_W_REF_B: if (cnt == RFC_LAST) nxt = S_LOAD;
      S_LOAD:    nxt = AFTER_LOAD;
      S_W_LOAD:  if (cnt == MRD_LAST) nxt = S_READY;
      S_READY:   if (mode_reload) nxt = S_LOAD;
      default:   nxt = S_IDLE;
    endcase
  end

  // Any change of state restarts the shared counter from zero.
  assign cnt_clr = (nxt != state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt == S_READY) done <= 1'b1;
    end
  end
endmodule

// File: rtl/sdr_init_cmdgen.sv
`timescale 1ns/1ps
module sdr_init_cmdgen
  import sdr_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input  init_state_e       state,
  input  logic [2:0]        burst_len,
  input  logic              burst_ilv,
  input  logic [2:0]        cas_lat,
  output logic              cke,
  output mem_cmd_t          cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba
);
  localparam int AP_BIT = 10;

  assign cke = (state != S_IDLE);
  assign ba  = '0;

  always_comb begin
    cmd  = CMD_NOP;
    addr = '0;
    unique case (state)
      S_PRE: begin
        cmd          = CMD_PRE;
        addr[AP_BIT] = 1'b1;
      end
      S_REF_A, S_REF_B: cmd = CMD_AREF;
      S_LOAD: begin
        cmd        = CMD_LOAD;
        addr[2:0]  = burst_len;
        addr[3]    = burst_ilv;
        addr[6:4]  = cas_lat;
      end
      default: cmd = CMD_NOP;
    endcase
  end
endmodule

// File: rtl/sdr_init_seq.sv
`timescale 1ns/1ps
module sdr_init_seq
  import sdr_init_pkg::*;
#(
  parameter int CLK_PS   = 5000,
  parameter int T_RP_PS  = 15000,
  parameter int T_RFC_PS = 60000,
  parameter int T_MRD_PS = 10000,
  parameter int ADDR_W   = 13,
  parameter int BA_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_stable,
  input  logic              mode_reload,
  input  logic [2:0]        burst_len,
  input  logic              burst_ilv,
  input  logic [2:0]        cas_lat,
  output logic              mem_cke,
  output logic              mem_cs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BA_W-1:0]   mem_ba,
  output logic [3:0]        seq_state,
  output logic              init_done
);
  localparam int WAIT_RP  = gap_cycles(T_RP_PS,  CLK_PS);
  localparam int WAIT_RFC = gap_cycles(T_RFC_PS, CLK_PS);
  localparam int WAIT_MRD = gap_cycles(T_MRD_PS, CLK_PS);
  localparam int MAX_A    = (WAIT_RP > WAIT_RFC) ? WAIT_RP : WAIT_RFC;
  localparam int MAX_WAIT = (MAX_A > WAIT_MRD) ? MAX_A : WAIT_MRD;
  localparam int CNT_W    = $clog2(MAX_WAIT + 2);

  init_state_e      st;
  logic             cnt_clr;
  logic [CNT_W-1:0] cnt;
  mem_cmd_t         cmd;

  sdr_init_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .cnt   (cnt)
  );

  sdr_init_fsm #(
    .WAIT_RP  (WAIT_RP),
    .WAIT_RFC (WAIT_RFC),
    .WAIT_MRD (WAIT_MRD),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_stable  (pwr_stable),
    .mode_reload (mode_reload),
    .cnt         (cnt),
    .state       (st),
    .cnt_clr     (cnt_clr),
    .done        (init_done)
  );

  sdr_init_cmdgen #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_cmd (
    .state     (st),
    .burst_len (burst_len),
    .burst_ilv (burst_ilv),
    .cas_lat   (cas_lat),
    .cke       (mem_cke),
    .cmd       (cmd),
    .addr      (mem_addr),
    .ba        (mem_ba)
  );

  assign mem_cs_n  = cmd.cs_n;
  assign mem_ras_n = cmd.ras_n;
  assign mem_cas_n = cmd.cas_n;
  assign mem_we_n  = cmd.we_n;
  assign seq_state = st;
endmodule

// File: rtl/sdr_init_chk.sv
`timescale 1ns/1ps
module sdr_init_chk #(
  parameter int WAIT_RP  = 2,
  parameter int WAIT_RFC = 11,
  parameter int WAIT_MRD = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_stable,
  input logic       mode_reload,
  input logic       mem_cke,
  input logic [3:0] cmd,
  input logic       a10,
  input logic [3:0] seq_state,
  input logic       init_done
);
  logic [3:0]  st_q;
  logic [15:0] run_q;
  logic [15:0] run_now;

  // Cycles already spent in the current state before this one.
  assign run_now = (seq_state == st_q) ? run_q + 16'd1 : 16'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= 4'd0;
      run_q <= 16'd0;
    end else begin
      st_q  <= seq_state;
      run_q <= run_now;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 4'd0) |-> (!mem_cke && cmd == 4'b0111 && !init_done)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 4'd0 && !pwr_stable) |=> (seq_state == 4'd0)); // R1
  AST_CKE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cke |=> mem_cke); // R2
  AST_PRE_AFTER_CKE: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 4'd1) |=> (seq_state == 4'd2)); // R2
  AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0010) |-> a10); // R3
  AST_WAIT_IS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state inside {4'd3, 4'd5, 4'd7, 4'd9}) |-> (cmd == 4'b0111)); // R4
  AST_RP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 4'd3) |-> (int'(run_now) < WAIT_RP)); // R4
  AST_RP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 4'd3 && int'(run_now) == WAIT_RP - 1) |=> (seq_state == 4'd4)); // R4
  AST_RFC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state inside {4'd5, 4'd7}) |-> (int'(run_now) < WAIT_RFC)); // R4
  AST_MRD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 4'd9) |-> (int'(run_now) < WAIT_MRD)); // R4
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done); // R7
  AST_DONE_IN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 4'd10) |-> init_done); // R7
  AST_RELOAD_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 4'd10 && mode_reload) |=> (seq_state == 4'd8)); // R8
  AST_LOAD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 4'd8 && st_q != 4'd8) |-> (st_q inside {4'd6, 4'd7, 4'd10})); // R9
endmodule

bind sdr_init_seq sdr_init_chk #(
  .WAIT_RP  (WAIT_RP),
  .WAIT_RFC (WAIT_RFC),
  .WAIT_MRD (WAIT_MRD)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pwr_stable  (pwr_stable),
  .mode_reload (mode_reload),
  .mem_cke     (mem_cke),
  .cmd         ({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}),
  .a10         (mem_addr[10]),
  .seq_state   (seq_state),
  .init_done   (init_done)
);

// File: tb/tb_sdr_init_seq.sv
`timescale 1ns/1ps
module tb_sdr_init_seq;
  localparam int AW = 13;
  localparam int BW = 2;
  // Instance a: long gaps at 5 ns; instance b: 20 ns period covers every gap.
  localparam int A_CLK = 5000,  A_RP = 15000, A_RFC = 60000, A_MRD = 10000;
  localparam int B_CLK = 20000, B_RP = 15000, B_RFC = 15000, B_MRD = 10000;

  function automatic int exp_wait(input int t, input int c);
    if (t <= c) return 0;
    return (t + c - 1) / c - 1;
  endfunction

  // Phase table: {state, cmd, cke, done, addr-check, length-select}
  // addr-check: 0 none, 1 bit 10 high, 2 mode word. length: 0 one cycle, 1 rp, 2 rfc, 3 mrd.
  localparam logic [13:0] PHASES [10] = '{
    {4'd1,  4'b0111, 1'b1, 1'b0, 2'd0, 2'd0},
    {4'd2,  4'b0010, 1'b1, 1'b0, 2'd1, 2'd0},
    {4'd3,  4'b0111, 1'b1, 1'b0, 2'd0, 2'd1},
    {4'd4,  4'b0001, 1'b1, 1'b0, 2'd0, 2'd0},
    {4'd5,  4'b0111, 1'b1, 1'b0, 2'd0, 2'd2},
    {4'd6,  4'b0001, 1'b1, 1'b0, 2'd0, 2'd0},
    {4'd7,  4'b0111, 1'b1, 1'b0, 2'd0, 2'd2},
    {4'd8,  4'b0000, 1'b1, 1'b0, 2'd2, 2'd0},
    {4'd9,  4'b0111, 1'b1, 1'b0, 2'd0, 2'd3},
    {4'd10, 4'b0111, 1'b1, 1'b1, 2'd0, 2'd0}
  };

  logic clk = 1'b0;
  logic rst_n, pwr_a, pwr_b, rl_a, rl_b, bilv;
  logic [2:0] blen, clat;
  logic a_cke, a_cs, a_ras, a_cas, a_we, a_done;
  logic b_cke, b_cs, b_ras, b_cas, b_we, b_done;
  logic [AW-1:0] a_addr, b_addr;
  logic [BW-1:0] a_ba, b_ba;
  logic [3:0] a_st, b_st;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sdr_init_seq #(.CLK_PS(A_CLK), .T_RP_PS(A_RP), .T_RFC_PS(A_RFC), .T_MRD_PS(A_MRD),
                 .ADDR_W(AW), .BA_W(BW)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_stable(pwr_a), .mode_reload(rl_a),
    .burst_len(blen), .burst_ilv(bilv), .cas_lat(clat),
    .mem_cke(a_cke), .mem_cs_n(a_cs), .mem_ras_n(a_ras), .mem_cas_n(a_cas),
    .mem_we_n(a_we), .mem_addr(a_addr), .mem_ba(a_ba), .seq_state(a_st),
    .init_done(a_done));

  sdr_init_seq #(.CLK_PS(B_CLK), .T_RP_PS(B_RP), .T_RFC_PS(B_RFC), .T_MRD_PS(B_MRD),
                 .ADDR_W(AW), .BA_W(BW)) dut_fast (
    .clk(clk), .rst_n(rst_n), .pwr_stable(pwr_b), .mode_reload(rl_b),
    .burst_len(blen), .burst_ilv(bilv), .cas_lat(clat),
    .mem_cke(b_cke), .mem_cs_n(b_cs), .mem_ras_n(b_ras), .mem_cas_n(b_cas),
    .mem_we_n(b_we), .mem_addr(b_addr), .mem_ba(b_ba), .seq_state(b_st),
    .init_done(b_done));

  task automatic check_eq(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic sample(input int sel, input int st, input int cmd, input int cke,
                        input int done, input int ak, input string tag);
    logic [3:0] s, c;
    logic k, d;
    logic [AW-1:0] ad;
    logic [BW-1:0] bk;
    logic [AW-1:0] mw;
    if (sel == 0) begin
      s = a_st; c = {a_cs, a_ras, a_cas, a_we}; k = a_cke; d = a_done; ad = a_addr; bk = a_ba;
    end else begin
      s = b_st; c = {b_cs, b_ras, b_cas, b_we}; k = b_cke; d = b_done; ad = b_addr; bk = b_ba;
    end
    check_eq(tag, "state", int'(s), st);
    check_eq(tag, "cmd", int'(c), cmd);
    check_eq(tag, "cke", int'(k), cke);
    check_eq(tag, "done", int'(d), done);
    if (ak == 1) check_eq("R3", "addr10", int'(ad[10]), 1);
    if (ak == 2) begin
      mw = '0;
      mw[6:0] = {clat, bilv, blen};
      check_eq("R6", "mode word", int'(ad), int'(mw));
      check_eq("R6", "bank", int'(bk), 0);
    end
  endtask

  task automatic run_walk(input int sel, input int wrp, input int wrfc, input int wmrd,
                          input string force_tag);
    if (sel == 0) pwr_a = 1'b1; else pwr_b = 1'b1;
    for (int p = 0; p < 10; p++) begin
      logic [13:0] ph;
      int n;
      string tag;
      ph = PHASES[p];
      case (ph[1:0])
        2'd1:    n = wrp;
        2'd2:    n = wrfc;
        2'd3:    n = wmrd;
        default: n = 1;
      endcase
      if (p == 0) tag = "R2";
      else if (ph[1:0] != 2'd0) tag = "R4";
      else if (ph[4]) tag = "R7";
      else tag = "R3";
      if (force_tag != "") tag = force_tag;
      if (p == 9) begin rl_a = 1'b0; rl_b = 1'b0; end  // release before ready
      for (int k = 0; k < n; k++) begin
        @(posedge clk); @(negedge clk);
        sample(sel, int'(ph[13:10]), int'(ph[9:6]), int'(ph[5]), int'(ph[4]),
               int'(ph[3:2]), tag);
      end
    end
  endtask

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int wa_rp, wa_rfc, wa_mrd, wb_rp, wb_rfc, wb_mrd;
    wa_rp = exp_wait(A_RP, A_CLK);  wa_rfc = exp_wait(A_RFC, A_CLK);  wa_mrd = exp_wait(A_MRD, A_CLK);
    wb_rp = exp_wait(B_RP, B_CLK);  wb_rfc = exp_wait(B_RFC, B_CLK);  wb_mrd = exp_wait(B_MRD, B_CLK);
    rst_n = 1'b0; pwr_a = 1'b0; pwr_b = 1'b0; rl_a = 1'b0; rl_b = 1'b0;
    blen = 3'b010; bilv = 1'b0; clat = 3'b011;
    repeat (3) @(negedge clk);
    sample(0, 0, 4'b0111, 0, 0, 0, "R1");  // reset values
    sample(1, 0, 4'b0111, 0, 0, 0, "R1");
    rst_n = 1'b1;
    repeat (4) begin
      @(posedge clk); @(negedge clk);
      sample(0, 0, 4'b0111, 0, 0, 0, "R1");
      sample(1, 0, 4'b0111, 0, 0, 0, "R1");
    end
    // R9: reload request in idle does nothing
    rl_a = 1'b1; rl_b = 1'b1;
    @(posedge clk); @(negedge clk);
    sample(0, 0, 4'b0111, 0, 0, 0, "R9");
    sample(1, 0, 4'b0111, 0, 0, 0, "R9");
    rl_b = 1'b0;
    // Full start-up walk with reload held high throughout (R9), long gaps (R4)
    run_walk(0, wa_rp, wa_rfc, wa_mrd, "");
    repeat (3) begin
      @(posedge clk); @(negedge clk);
      sample(0, 10, 4'b0111, 1, 1, 0, "R7");
    end
    // R8: reload with new field values
    blen = 3'b011; bilv = 1'b1; clat = 3'b010;
    rl_a = 1'b1;
    @(posedge clk); @(negedge clk);
    sample(0, 8, 4'b0000, 1, 1, 2, "R8");
    rl_a = 1'b0;
    for (int k = 0; k < wa_mrd; k++) begin
      @(posedge clk); @(negedge clk);
      sample(0, 9, 4'b0111, 1, 1, 0, "R8");
    end
    @(posedge clk); @(negedge clk);
    sample(0, 10, 4'b0111, 1, 1, 0, "R8");
    // R5: every gap covered by the clock period
    run_walk(1, wb_rp, wb_rfc, wb_mrd, "R5");
    // R10: reset from ready, then reset in the middle of a refresh wait
    pwr_a = 1'b0; pwr_b = 1'b0;
    rst_n = 1'b0; #1;
    sample(0, 0, 4'b0111, 0, 0, 0, "R10");
    sample(1, 0, 4'b0111, 0, 0, 0, "R10");
    @(negedge clk); rst_n = 1'b1; pwr_a = 1'b1;
    repeat (6) @(negedge clk);
    check_eq("R4", "mid state", int'(a_st), 5);
    rst_n = 1'b0; #1;
    sample(0, 0, 4'b0111, 0, 0, 0, "R10");
    @(negedge clk); pwr_a = 1'b0; rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    sample(0, 0, 4'b0111, 0, 0, 0, "R10");
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule